// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the 32-bit memory address for one operand of a register-based processor. Each cycle it takes the addressing mode, the operand size and every raw ingredient the address may need: the selected base register value, the index register value with its width and scale fields, the displacement carried in the extension words, and the address of the current instruction. From these it produces the effective address. For auto-increment and auto-decrement modes it also produces the updated base register value. Register selection, instruction fetch and memory-indirect addressing belong to the surrounding pipeline.

The result is registered and appears one clock after the request. A legacy compatibility input forces the index scale to one and turns on an alignment check. That check flags word and long accesses to odd addresses and still delivers the address. All arithmetic wraps modulo 2^32.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (register indirect) gives an effective address equal to `base_reg`, and does not request write-back.
- R2: Mode code 1 (post-increment) uses `base_reg` as the address and writes back `base_reg` plus the step. The step is 1, 2 or 4 for `op_size` codes 0 (byte), 1 (word) and 2 (long). Code 3 is treated as long.
- R3: Mode code 2 (pre-decrement) subtracts the step first. The reduced value is both the address and the write-back value.
- R4: Mode code 3 adds `disp_val[15:0]`, sign-extended to 32 bits, to `base_reg`.
- R5: Mode code 4 (brief index) adds `base_reg`, the scaled index and `ext_word[7:0]` sign-extended. The index is `index_reg` when `index_long`=1, else `index_reg[15:0]` sign-extended. The null flags have no effect in this mode.
- R6: The index is multiplied by 1, 2, 4 or 8 for `ext_word[10:9]` codes 0 to 3. When `legacy_mode`=1 the multiplier is 1 whatever the code.
- R7: Mode code 5 (full index) adds base, scaled index and base displacement. The displacement is `disp_val` when `disp_long`=1, else `disp_val[15:0]` sign-extended. Each term whose flag (`null_base`, `null_index`, `null_disp`) is 1 contributes zero.
- R8: Modes 6, 7 and 8 behave like modes 3, 4 and 5 with the base replaced by `inst_addr`+2. In mode 8, `null_base` zeroes that base.
- R9: Mode code 9 gives `disp_val[15:0]` sign-extended. Mode code 10 gives `disp_val` unchanged.
- R10: `misaligned` is 1 exactly when `legacy_mode`=1, `op_size` is not byte, the mode is valid and address bit 0 is 1. The address is delivered regardless.
- R11: All address sums and differences wrap modulo 2^32.
- R12: Mode codes 11 to 15 give address 0, write-back value 0, no write-back, no misalignment and `bad_mode`=1.
- R13: Results appear one clock after a cycle with `in_valid`=1, with `out_valid`=1. `out_valid` is 0 otherwise. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing mode code |
| op_size | input | 2 | Operand size code |
| legacy_mode | input | 1 | Compatibility setting: scale 1, alignment check on |
| base_reg | input | 32 | Base address register value |
| index_reg | input | 32 | Index register value |
| index_long | input | 1 | 1: full index, 0: low 16 bits sign-extended |
| ext_word | input | 16 | Index extension word (scale, brief displacement) |
| disp_val | input | 32 | Displacement or absolute address from extension words |
| disp_long | input | 1 | Full-index base displacement is 32 bits |
| null_base | input | 1 | Full-index base term is zero |
| null_index | input | 1 | Full-index index term is zero |
| null_disp | input | 1 | Full-index displacement term is zero |
| inst_addr | input | 32 | Address of the instruction start |
| out_valid | output | 1 | Result valid |
| eff_addr | output | 32 | Effective address |
| wb_en | output | 1 | Base register write-back requested |
| wb_value | output | 32 | New base register value |
| misaligned | output | 1 | Odd address on a multi-byte legacy access |
| bad_mode | output | 1 | Unknown mode code |

## Verification
The bench targets the places where sign extension and step size are easy to get wrong:
- A 0x8000 displacement, a 0xFFFF short index and a 0x80 brief displacement each have to go negative. A design that zero-extends them lands 64 KiB or 256 bytes too high.
- Pre-decrement from zero must wrap to the top of the address space.
- Pre-decrement must address the reduced value. A design that addresses the old value shows a mismatch between address and write-back.
- With legacy mode on, a scale code of 3 must still give a multiplier of one.
- The PC-relative modes must use the instruction address plus two, not plus zero.

Odd byte accesses and odd non-legacy accesses must not raise the misalignment flag, while odd legacy word accesses must. Unknown mode codes must give an all-zero result with only the mode error set.

// File: rtl/ea_gen_pkg.sv
// Package: shared widths, mode and size codes for the address generator.
// Assumes a 32-bit address space; mode codes above ABS_LONG are invalid.
package ea_gen_pkg;
    localparam int ADDR_W  = 32;
    localparam int EXT_W   = 16;
    localparam int MODE_W  = 4;
    localparam int SIZE_W  = 2;
    localparam int SHORT_W = 16;
    localparam int BRIEF_W = 8;

    typedef enum logic [MODE_W-1:0] {
        M_IND        = 4'd0,
        M_POSTINC    = 4'd1,
        M_PREDEC     = 4'd2,
        M_DISP       = 4'd3,
        M_BRIEF_IDX  = 4'd4,
        M_FULL_IDX   = 4'd5,
        M_PC_DISP    = 4'd6,
        M_PC_BRIEF   = 4'd7,
        M_PC_FULL    = 4'd8,
        M_ABS_SHORT  = 4'd9,
        M_ABS_LONG   = 4'd10
    } mode_e;

    localparam logic [SIZE_W-1:0] SZ_BYTE = 2'd0;
    localparam logic [SIZE_W-1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/ea_step.sv
// Step unit: converts the operand size code into the auto-modify step.
// Assumes code 3 is treated as a long operand.
module ea_step
    import ea_gen_pkg::*;
(
    input  logic [SIZE_W-1:0] op_size,
    output logic [ADDR_W-1:0] step
);
    // Select byte count from the size code.
    always_comb begin
        case (op_size)
            SZ_BYTE: step = ADDR_W'(1);
            SZ_WORD: step = ADDR_W'(2);
            default: step = ADDR_W'(4);
        endcase
    end
endmodule

// File: rtl/ea_index.sv
// Index unit: widens the index register (full or short sign-extended)
// and applies the 1/2/4/8 scale from the extension word.
// Assumes legacy mode pins the scale to one.
module ea_index
    import ea_gen_pkg::*;
(
    input  logic [ADDR_W-1:0] index_reg,
    input  logic              index_long,
    input  logic [1:0]        scale_code,
    input  logic              legacy_mode,
    output logic [ADDR_W-1:0] scaled_index
);
    logic [ADDR_W-1:0] widened;
    logic [1:0]        shamt;

    // Pick full register or sign-extended low half.
    always_comb begin
        if (index_long)
            widened = index_reg;
        else
            widened = {{(ADDR_W-SHORT_W){index_reg[SHORT_W-1]}}, index_reg[SHORT_W-1:0]};
    end

    // Apply the power-of-two scale, wrapping in the address width.
    always_comb begin
        shamt        = legacy_mode ? 2'd0 : scale_code;
        scaled_index = widened << shamt;
    end
endmodule

// File: rtl/ea_select.sv
// Mode selector: forms the effective address and write-back value for
// every supported mode from precomputed step and scaled index.
// Assumes null flags only matter in the full-index modes.
module ea_select
    import ea_gen_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] base_reg,
    input  logic [ADDR_W-1:0] inst_addr,
    input  logic [ADDR_W-1:0] step,
    input  logic [ADDR_W-1:0] scaled_index,
    input  logic [EXT_W-1:0]  ext_word,
    input  logic [ADDR_W-1:0] disp_val,
    input  logic              disp_long,
    input  logic              null_base,
    input  logic              null_index,
    input  logic              null_disp,
    output logic [ADDR_W-1:0] ea,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_value,
    output logic              bad_mode
);
    logic [ADDR_W-1:0] pc_base;
    logic [ADDR_W-1:0] disp_short;
    logic [ADDR_W-1:0] disp_brief;
    logic [ADDR_W-1:0] disp_full;
    logic [ADDR_W-1:0] full_base_term;
    logic [ADDR_W-1:0] full_idx_term;
    logic [ADDR_W-1:0] full_disp_term;
    logic [ADDR_W-1:0] full_tail;
    logic              unused_ext;

    assign unused_ext = ^{ext_word[EXT_W-1:11], ext_word[8]};

    // Precompute the extended displacements and the PC-relative base.
    always_comb begin
        pc_base    = inst_addr + ADDR_W'(2);
        disp_short = {{(ADDR_W-SHORT_W){disp_val[SHORT_W-1]}}, disp_val[SHORT_W-1:0]};
        disp_brief = {{(ADDR_W-BRIEF_W){ext_word[BRIEF_W-1]}}, ext_word[BRIEF_W-1:0]};
        disp_full  = disp_long ? disp_val : disp_short;
    end

    // Mask the null components of the full-index form.
    always_comb begin
        full_idx_term  = null_index ? '0 : scaled_index;
        full_disp_term = null_disp  ? '0 : disp_full;
        full_tail      = full_idx_term + full_disp_term;
        if (null_base)
            full_base_term = '0;
        else if (mode == M_PC_FULL)
            full_base_term = pc_base;
        else
            full_base_term = base_reg;
    end

    // Mode multiplexer for address and write-back.
    always_comb begin
        ea       = '0;
        wb_en    = 1'b0;
        wb_value = '0;
        bad_mode = 1'b0;
        case (mode)
            M_IND:       ea = base_reg;
            M_POSTINC: begin
                ea       = base_reg;
                wb_en    = 1'b1;
                wb_value = base_reg + step;
            end
            M_PREDEC: begin
                ea       = base_reg - step;
                wb_en    = 1'b1;
                wb_value = base_reg - step;
            end
            M_DISP:      ea = base_reg + disp_short;
            M_BRIEF_IDX: ea = base_reg + scaled_index + disp_brief;
            M_FULL_IDX:  ea = full_base_term + full_tail;
            M_PC_DISP:   ea = pc_base + disp_short;
            M_PC_BRIEF:  ea = pc_base + scaled_index + disp_brief;
            M_PC_FULL:   ea = full_base_term + full_tail;
            M_ABS_SHORT: ea = disp_short;
            M_ABS_LONG:  ea = disp_val;
            default:     bad_mode = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_gen.sv
// Top: effective address generator with a single output register stage.
// Assumes inputs are stable for the request cycle; result follows one
// clock later. Alignment check applies only in legacy mode.
module ea_gen
    import ea_gen_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [MODE_W-1:0]   mode,
    input  logic [SIZE_W-1:0]   op_size,
    input  logic                legacy_mode,
    input  logic [ADDR_W-1:0]   base_reg,
    input  logic [ADDR_W-1:0]   index_reg,
    input  logic                index_long,
    input  logic [EXT_W-1:0]    ext_word,
    input  logic [ADDR_W-1:0]   disp_val,
    input  logic                disp_long,
    input  logic                null_base,
    input  logic                null_index,
    input  logic                null_disp,
    input  logic [ADDR_W-1:0]   inst_addr,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   eff_addr,
    output logic                wb_en,
    output logic [ADDR_W-1:0]   wb_value,
    output logic                misaligned,
    output logic                bad_mode
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] scaled_index;
    logic [ADDR_W-1:0] sel_ea;
    logic              sel_wb_en;
    logic [ADDR_W-1:0] sel_wb_value;
    logic              sel_bad;
    logic              sel_misaligned;

    ea_step u_step (
        .op_size (op_size),
        .step    (step)
    );

    ea_index u_index (
        .index_reg    (index_reg),
        .index_long   (index_long),
        .scale_code   (ext_word[10:9]),
        .legacy_mode  (legacy_mode),
        .scaled_index (scaled_index)
    );

    ea_select u_select (
        .mode         (mode),
        .base_reg     (base_reg),
        .inst_addr    (inst_addr),
        .step         (step),
        .scaled_index (scaled_index),
        .ext_word     (ext_word),
        .disp_val     (disp_val),
        .disp_long    (disp_long),
        .null_base    (null_base),
        .null_index   (null_index),
        .null_disp    (null_disp),
        .ea           (sel_ea),
        .wb_en        (sel_wb_en),
        .wb_value     (sel_wb_value),
        .bad_mode     (sel_bad)
    );

    // Flag odd multi-byte legacy accesses on valid modes.
    always_comb begin
        sel_misaligned = legacy_mode && (op_size != SZ_BYTE) && sel_ea[0] && !sel_bad;
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            eff_addr   <= '0;
            wb_en      <= 1'b0;
            wb_value   <= '0;
            misaligned <= 1'b0;
            bad_mode   <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            eff_addr   <= sel_ea;
            wb_en      <= sel_wb_en;
            wb_value   <= sel_wb_value;
            misaligned <= sel_misaligned;
            bad_mode   <= sel_bad;
        end
    end

    AST_INDIRECT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) == M_IND) |-> (eff_addr == $past(base_reg) && !wb_en)); // R1
    AST_POSTINC_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) == M_POSTINC && $past(op_size) == SZ_BYTE)
            |-> (wb_value == eff_addr + 32'd1)); // R2
    AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) == M_PREDEC) |-> (wb_en && wb_value == eff_addr)); // R3
    AST_MISALIGN_COND: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (eff_addr[0] && $past(legacy_mode) && $past(op_size) != SZ_BYTE)); // R10
    AST_BAD_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mode |-> (eff_addr == '0 && !wb_en && wb_value == '0 && !misaligned)); // R12
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid)); // R13
endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  op_size = '0;
    logic        legacy_mode = 1'b0;
    logic [31:0] base_reg = '0;
    logic [31:0] index_reg = '0;
    logic        index_long = 1'b0;
    logic [15:0] ext_word = '0;
    logic [31:0] disp_val = '0;
    logic        disp_long = 1'b0;
    logic        null_base = 1'b0;
    logic        null_index = 1'b0;
    logic        null_disp = 1'b0;
    logic [31:0] inst_addr = '0;
    logic        out_valid;
    logic [31:0] eff_addr;
    logic        wb_en;
    logic [31:0] wb_value;
    logic        misaligned;
    logic        bad_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [31:0] ea;
        logic        we;
        logic [31:0] wb;
        logic        mis;
        logic        bad;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    ea_gen dut (.*);

    function automatic logic [31:0] sx(input logic [31:0] v, input int bits);
        logic [31:0] r;
        r = v & ((32'd1 << bits) - 32'd1);
        if (v[bits-1]) r = r | ~((32'd1 << bits) - 32'd1);
        return r;
    endfunction

    // Reference model built from the requirement text.
    function automatic exp_t model();
        exp_t e;
        logic [31:0] stp, idx, mul, pcb, bd, b;
        e = '0;
        stp = (op_size == 2'd0) ? 32'd1 : (op_size == 2'd1) ? 32'd2 : 32'd4;
        mul = legacy_mode ? 32'd1 : (32'd1 << ext_word[10:9]);
        idx = (index_long ? index_reg : sx(index_reg, 16)) * mul;
        pcb = inst_addr + 32'd2;
        bd  = disp_long ? disp_val : sx(disp_val, 16);
        case (mode)
            4'd0: e.ea = base_reg;
            4'd1: begin e.ea = base_reg; e.we = 1'b1; e.wb = base_reg + stp; end
            4'd2: begin e.ea = base_reg - stp; e.we = 1'b1; e.wb = e.ea; end
            4'd3: e.ea = base_reg + sx(disp_val, 16);
            4'd4: e.ea = base_reg + idx + sx({24'd0, ext_word[7:0]}, 8);
            4'd5, 4'd8: begin
                b = (mode == 4'd5) ? base_reg : pcb;
                e.ea = (null_base ? 32'd0 : b) + (null_index ? 32'd0 : idx)
                     + (null_disp ? 32'd0 : bd);
            end
            4'd6: e.ea = pcb + sx(disp_val, 16);
            4'd7: e.ea = pcb + idx + sx({24'd0, ext_word[7:0]}, 8);
            4'd9: e.ea = sx(disp_val, 16);
            4'd10: e.ea = disp_val;
            default: e.bad = 1'b1;
        endcase
        e.mis = legacy_mode && op_size != 2'd0 && e.ea[0] && !e.bad;
        return e;
    endfunction

    // Driver: present one request and push its expected result.
    task automatic send(input string tag);
        in_valid = 1'b1;
        exp_q.push_back(model());
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic clear_fields();
        op_size = 0; legacy_mode = 0; base_reg = 0; index_reg = 0; index_long = 0;
        ext_word = 0; disp_val = 0; disp_long = 0; null_base = 0; null_index = 0;
        null_disp = 0; inst_addr = 0;
    endtask

    // Monitor: pop and compare on every valid result, away from the edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R13 unexpected out_valid: actual=1 expected=0");
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (eff_addr !== e.ea || wb_en !== e.we || wb_value !== e.wb ||
                    misaligned !== e.mis || bad_mode !== e.bad) begin
                    failures++;
                    $display("FAIL %s actual ea=%h we=%0b wb=%h mis=%0b bad=%0b expected ea=%h we=%0b wb=%h mis=%0b bad=%0b",
                             t, eff_addr, wb_en, wb_value, misaligned, bad_mode,
                             e.ea, e.we, e.wb, e.mis, e.bad);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        checks++;
        if (out_valid !== 0 || eff_addr !== 0 || wb_en !== 0 || wb_value !== 0 ||
            misaligned !== 0 || bad_mode !== 0) begin
            failures++;
            $display("FAIL R13 reset: actual v=%0b ea=%h expected all zero", out_valid, eff_addr);
        end

        clear_fields(); mode = 0; base_reg = 32'h0000_1000; send("R1 indirect");
        mode = 1; op_size = 0; base_reg = 32'h0000_2001; send("R2 postinc byte");
        mode = 1; op_size = 1; base_reg = 32'h0000_2000; send("R2 postinc word");
        mode = 1; op_size = 2; base_reg = 32'h0000_2000; send("R2 postinc long");
        mode = 1; op_size = 3; base_reg = 32'hFFFF_FFFE; send("R2 R11 postinc code3 wrap");
        mode = 2; op_size = 0; base_reg = 32'h0000_3000; send("R3 predec byte");
        mode = 2; op_size = 2; base_reg = 32'h0000_3000; send("R3 predec long");
        mode = 2; op_size = 1; base_reg = 32'h0; send("R3 R11 predec wrap");
        mode = 3; base_reg = 32'h0001_0000; disp_val = 32'h0000_7FFE; send("R4 disp positive");
        mode = 3; disp_val = 32'hABCD_8000; send("R4 disp negative");
        mode = 3; base_reg = 32'hFFFF_FFF0; disp_val = 32'h0000_0020; send("R11 disp wrap");
        clear_fields();
        mode = 4; base_reg = 32'h1000; index_reg = 32'h0001_0004; index_long = 1;
        ext_word = 16'h0010; send("R5 brief long index");
        mode = 4; index_long = 0; index_reg = 32'h1234_FFFF; ext_word = 16'h0080; send("R5 brief short neg index");
        mode = 4; null_base = 1; null_index = 1; index_long = 1; index_reg = 32'h40;
        ext_word = 16'h0000; send("R5 brief ignores nulls");
        clear_fields();
        mode = 4; base_reg = 32'h100; index_reg = 32'h10; index_long = 1;
        ext_word = 16'h0200; send("R6 scale 2");
        ext_word = 16'h0400; send("R6 scale 4");
        ext_word = 16'h0600; send("R6 scale 8");
        legacy_mode = 1; send("R6 legacy scale forced 1");
        clear_fields();
        mode = 5; base_reg = 32'h1000; index_reg = 32'h8; index_long = 1; ext_word = 16'h0200;
        disp_val = 32'h1234_5678; disp_long = 1; send("R7 full 32 disp");
        disp_long = 0; disp_val = 32'h0000_FFF0; send("R7 full 16 disp neg");
        null_base = 1; send("R7 null base");
        null_base = 0; null_index = 1; send("R7 null index");
        null_index = 0; null_disp = 1; send("R7 null disp");
        null_base = 1; null_index = 1; send("R7 all null");
        clear_fields(); inst_addr = 32'h0000_4000;
        mode = 6; disp_val = 32'h0000_0010; send("R8 pc disp");
        mode = 7; index_reg = 32'h4; index_long = 1; ext_word = 16'h02FE; send("R8 pc brief");
        mode = 8; disp_val = 32'h100; base_reg = 32'h9999_0000; send("R8 pc full");
        null_base = 1; send("R8 pc full null base");
        clear_fields();
        mode = 9; disp_val = 32'h0000_8000; send("R9 abs short");
        mode = 10; disp_val = 32'h00FF_8001; send("R9 abs long");
        clear_fields(); mode = 0; base_reg = 32'h1001;
        legacy_mode = 1; op_size = 1; send("R10 legacy odd word");
        op_size = 0; send("R10 legacy odd byte");
        legacy_mode = 0; op_size = 2; send("R10 non-legacy odd long");
        legacy_mode = 1; mode = 2; op_size = 1; base_reg = 32'h2001; send("R10 R3 predec misaligned");
        clear_fields(); legacy_mode = 1; op_size = 1; base_reg = 32'h1001;
        mode = 11; send("R12 invalid 11");
        mode = 15; send("R12 invalid 15");
        // R13 idle cycles produce no result
        mode = 0;
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0 || out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R13 drain: actual pending=%0d valid=%0b expected 0 0", exp_q.size(), out_valid);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule